// File: doc/BRIEF.md
# Electrical Idle Inference Monitor

This block watches one lane of a receive symbol stream: a word of bytes each clock, with one control flag per byte and a valid input that signals symbol lock. It infers that the link partner has gone to electrical idle without an explicit indication from the analog side. It does this by expecting some event to recur and raising a flag when that event stays away for a whole timed window.

A three-bit criterion select, driven by the link training controller, picks the check. The top bit enables inference. The low two bits choose the expected event and the window: comma symbols over a long fixed-time window, training ordered sets over a short unit-interval window, or an exit from electrical idle over either a rate-dependent unit-interval window or a long fixed-time window. A rate input selects first- or second-generation timing. All windows are parameters in clock cycles. Unit-interval windows are derived from the number of unit intervals one clock covers. The inferred-idle flag and the active-criterion indication are registered outputs.

Top module: `eii_monitor`

## Requirements
- R1: While sel_i[2] is 0, the window counter is held, and idle_o and act_o read 0 after the next clock edge.
- R2: With sel_i = 3'b100, the event is a valid word carrying a comma (control flag 1, byte value 0xBC) in any byte lane. This covers skip ordered sets. The window is CYC_128US_G1 cycles when gen2_i = 0 and CYC_128US_G2 cycles when gen2_i = 1.
- R3: With sel_i = 3'b101, the event is a training ordered set: a valid word with a comma in byte lane 0, followed by the next valid word carrying data byte 0x4A or 0x45 (control flag 0) in lane TS_ID_LANE (default 2). Words with rx_valid_i low in between do not break the pair. The window is ceil(1280 / UI_PER_CYC) cycles at both rates.
- R4: With sel_i = 3'b110, the event is an electrical idle exit. The window is ceil(2000 / UI_PER_CYC) cycles at gen2_i = 0 and ceil(16000 / UI_PER_CYC) at gen2_i = 1.
- R5: With sel_i = 3'b111, the event is an electrical idle exit over CYC_128US_G1 cycles at gen2_i = 0. At gen2_i = 1 this code is inactive: idle_o and act_o stay 0.
- R6: Words sampled while rx_valid_i is 0 produce no event, and those cycles still count toward the window.
- R7: An idle exit is a falling edge of rx_eidle_i after a SYNC_STAGES-flop synchroniser. A fall first sampled at edge a counts as an event at edge a + SYNC_STAGES. A rising edge is no event.
- R8: The event edge, or the edge where a new configuration is first seen, restarts the window. If none of the next W edges samples an event, idle_o is 1 after the W-th edge and 0 after the one before it. An event exactly on the W-th edge keeps idle_o at 0.
- R9: Once set, idle_o stays 1 until the edge that samples the selected event, which clears it.
- R10: A change of sel_i or gen2_i restarts the window and clears idle_o on the edge that first samples the new value.
- R11: act_o and crit_o (equal to sel_i[1:0]) report the sampled criterion one edge after it is applied. act_o is 1 only for an enabled criterion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Criterion select: enable bit plus criterion code |
| gen2_i | input | 1 | 1 selects second-generation rate timing |
| rx_data_i | input | 8*LANES | Received symbol bytes, lane 0 in the low byte |
| rx_ctl_i | input | LANES | Per-byte control flag, 1 = control symbol |
| rx_valid_i | input | 1 | Symbol lock; data evaluated only while high |
| rx_eidle_i | input | 1 | Asynchronous receive electrical idle indication |
| idle_o | output | 1 | Inferred electrical idle flag |
| act_o | output | 1 | A criterion is enabled |
| crit_o | output | 2 | Criterion code currently applied |

## Verification
The bench uses UI_PER_CYC = 40, which gives training-set and first-rate exit windows of 32 and 50 cycles and a second-rate exit window of 400. The fixed-time windows are shortened to 60 and 90 cycles. These values keep every criterion at both rates in reach, with the event placed on the last edge of the window, one edge past it, and after the flag has set. SYNC_STAGES stays at 2, so the synchroniser delay of the exit path is exercised at its real depth.

// File: rtl/eii_pkg.sv
package eii_pkg;

    localparam logic [7:0] K_COM  = 8'hBC;
    localparam logic [7:0] TS1_ID = 8'h4A;
    localparam logic [7:0] TS2_ID = 8'h45;

    localparam int UI_TS     = 1280;
    localparam int UI_EX_G1  = 2000;
    localparam int UI_EX_G2  = 16000;

    typedef enum logic [1:0] {
        CR_COMMA   = 2'b00,
        CR_TSET    = 2'b01,
        CR_EXIT_UI = 2'b10,
        CR_EXIT_T  = 2'b11
    } crit_e;

    typedef struct packed {
        logic com;
        logic ts;
    } sym_ev_t;

    typedef struct packed {
        logic  en;
        crit_e crit;
        logic  gen2;
    } cfg_t;

    function automatic int ui2cyc(input int ui, input int upc);
        return (ui + upc - 1) / upc;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eii_sym_scan.sv
module eii_sym_scan
    import eii_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int TS_ID_LANE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [8*LANES-1:0] data_i,
    input  logic [LANES-1:0]   ctl_i,
    input  logic               valid_i,
    output sym_ev_t            ev_o
);
    logic [LANES-1:0] com_lane;
    logic             com0_pend;
    logic [7:0]       id_byte;
    logic             id_ok;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign com_lane[i] = ctl_i[i] && (data_i[8*i +: 8] == K_COM);
        end
    endgenerate

    assign id_byte = data_i[8*TS_ID_LANE +: 8];
    assign id_ok   = !ctl_i[TS_ID_LANE] && ((id_byte == TS1_ID) || (id_byte == TS2_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            com0_pend <= 1'b0;
        end else if (valid_i) begin
            com0_pend <= com_lane[0];
        end
    end

    always_comb begin
        ev_o     = '0;
        ev_o.com = valid_i && (|com_lane);
        ev_o.ts  = valid_i && com0_pend && id_ok;
    end
endmodule

// File: rtl/eii_exit_det.sv
module eii_exit_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eidle_i,
    output logic exit_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= eidle_i;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[s] <= 1'b0;
                end else begin
                    sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    assign exit_o = last_q && !sync_q[STAGES-1];
endmodule

// File: rtl/eii_window.sv
module eii_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          idle_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst || !en_i || restart_i) begin
            cnt_q  <= '0;
            idle_o <= 1'b0;
        end else if (cnt_q != limit_i) begin
            cnt_q  <= cnt_inc;
            idle_o <= idle_o || (cnt_inc == limit_i);
        end
    end
endmodule

// File: rtl/eii_monitor.sv
module eii_monitor
    import eii_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int TS_ID_LANE   = 2,
    parameter int UI_PER_CYC   = 40,
    parameter int CYC_128US_G1 = 8000,
    parameter int CYC_128US_G2 = 16000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         sel_i,
    input  logic               gen2_i,
    input  logic [8*LANES-1:0] rx_data_i,
    input  logic [LANES-1:0]   rx_ctl_i,
    input  logic               rx_valid_i,
    input  logic               rx_eidle_i,
    output logic               idle_o,
    output logic               act_o,
    output logic [1:0]         crit_o
);
    localparam int W_TS    = ui2cyc(UI_TS, UI_PER_CYC);
    localparam int W_EX_G1 = ui2cyc(UI_EX_G1, UI_PER_CYC);
    localparam int W_EX_G2 = ui2cyc(UI_EX_G2, UI_PER_CYC);
    localparam int W_MAX   = imax(imax(W_TS, W_EX_G1), imax(W_EX_G2, imax(CYC_128US_G1, CYC_128US_G2)));
    localparam int CW      = $clog2(W_MAX + 1);

    cfg_t          cfg_d;
    cfg_t          cfg_q;
    sym_ev_t       sym_ev;
    logic          exit_ev;
    logic          sel_ev;
    logic          cfg_chg;
    logic [CW-1:0] limit;

    eii_sym_scan #(.LANES(LANES), .TS_ID_LANE(TS_ID_LANE)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .data_i  (rx_data_i),
        .ctl_i   (rx_ctl_i),
        .valid_i (rx_valid_i),
        .ev_o    (sym_ev)
    );

    eii_exit_det #(.STAGES(SYNC_STAGES)) u_exit (
        .clk     (clk),
        .rst     (rst),
        .eidle_i (rx_eidle_i),
        .exit_o  (exit_ev)
    );

    always_comb begin
        cfg_d.crit = crit_e'(sel_i[1:0]);
        cfg_d.gen2 = gen2_i;
        cfg_d.en   = sel_i[2] && !((cfg_d.crit == CR_EXIT_T) && gen2_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_chg = (cfg_d != cfg_q);

    always_comb begin
        case (cfg_d.crit)
            CR_COMMA: begin
                sel_ev = sym_ev.com;
                limit  = cfg_d.gen2 ? CW'(CYC_128US_G2) : CW'(CYC_128US_G1);
            end
            CR_TSET: begin
                sel_ev = sym_ev.ts;
                limit  = CW'(W_TS);
            end
            CR_EXIT_UI: begin
                sel_ev = exit_ev;
                limit  = cfg_d.gen2 ? CW'(W_EX_G2) : CW'(W_EX_G1);
            end
            default: begin
                sel_ev = exit_ev;
                limit  = CW'(CYC_128US_G1);
            end
        endcase
    end

    eii_window #(.CW(CW)) u_win (
        .clk       (clk),
        .rst       (rst),
        .en_i      (cfg_d.en),
        .restart_i (cfg_chg || sel_ev),
        .limit_i   (limit),
        .idle_o    (idle_o)
    );

    assign act_o  = cfg_q.en;
    assign crit_o = cfg_q.crit;
endmodule

// File: rtl/eii_monitor_chk.sv
module eii_monitor_chk
    import eii_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] sel_i,
    input logic       gen2_i,
    input logic [7:0] lane0_i,
    input logic       ctl0_i,
    input logic       rx_valid_i,
    input logic       idle_o,
    input logic       act_o
);
    // R1
    a_r1_inactive_low: assert property (@(posedge clk) disable iff (rst)
        !sel_i[2] |=> (!idle_o && !act_o));

    // R5
    a_r5_gen2_time_off: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'b111 && gen2_i) |=> (!idle_o && !act_o));

    // R2
    a_r2_comma_clears: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'b100 && rx_valid_i && ctl0_i && lane0_i == K_COM) |=> !idle_o);

    // R10
    a_r10_rise_stable_cfg: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_o) |-> ($past(sel_i) == sel_i && $past(gen2_i) == gen2_i));

    // R11
    a_r11_act_needs_enable: assert property (@(posedge clk) disable iff (rst)
        act_o |-> $past(sel_i[2]));
endmodule

bind eii_monitor eii_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel_i),
    .gen2_i     (gen2_i),
    .lane0_i    (rx_data_i[7:0]),
    .ctl0_i     (rx_ctl_i[0]),
    .rx_valid_i (rx_valid_i),
    .idle_o     (idle_o),
    .act_o      (act_o)
);

// File: tb/eii_monitor_bench.sv
module eii_monitor_bench;
    localparam int CLK_P   = 10;
    localparam int SYNC    = 2;
    localparam int W_C1    = 60;
    localparam int W_C2    = 90;
    localparam int W_TS    = 32;
    localparam int W_EX1   = 50;
    localparam int W_EX2   = 400;
    localparam int K_COMMA = 0;
    localparam int K_TS    = 1;
    localparam int K_EXIT  = 2;
    localparam int S_IDLE  = 0;
    localparam int S_ACT   = 1;
    localparam int S_CRIT  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'b000;
    logic        gen2 = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctl = '0;
    logic        rx_valid = 1'b1;
    logic        rx_eidle = 1'b1;
    logic        idle;
    logic        act;
    logic [1:0]  crit;

    int edges = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    eii_monitor #(
        .LANES(4), .TS_ID_LANE(2), .UI_PER_CYC(40),
        .CYC_128US_G1(W_C1), .CYC_128US_G2(W_C2), .SYNC_STAGES(SYNC)
    ) u_eii_monitor (
        .clk(clk), .rst(rst), .sel_i(sel), .gen2_i(gen2),
        .rx_data_i(rx_data), .rx_ctl_i(rx_ctl), .rx_valid_i(rx_valid),
        .rx_eidle_i(rx_eidle), .idle_o(idle), .act_o(act), .crit_o(crit)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) edges = edges + 1;

    task automatic check(input string tag, input int actual, input int expv);
        n_chk++;
        if (actual != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, actual, expv, edges);
        end
    endtask

    // monitor: compare scoreboard items due after the current edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == edges) begin
                case (sb[i].sig)
                    S_IDLE:  check(sb[i].tag, int'(idle), sb[i].val);
                    S_ACT:   check(sb[i].tag, int'(act), sb[i].val);
                    default: check(sb[i].tag, int'(crit), sb[i].val);
                endcase
                sb.delete(i);
            end
        end
    end

    task automatic push_exp(input int cyc, input int sig, input int val, input string tag);
        exp_t e;
        e.cyc = cyc; e.sig = sig; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic idle_bus();
        rx_data = '0; rx_ctl = '0; rx_valid = 1'b1;
    endtask

    // make the selected event land on edge x
    task automatic fire(input int kind, input int x);
        if (kind == K_COMMA) begin
            wait_until(x - 1);
            rx_ctl = 4'b1000; rx_data = 32'hBC00_0000;
            @(negedge clk); idle_bus();
        end else if (kind == K_TS) begin
            wait_until(x - 2);
            rx_ctl = 4'b0001; rx_data = 32'h0000_00BC;
            @(negedge clk);
            rx_ctl = 4'b0000; rx_data = 32'h004A_0000;
            @(negedge clk); idle_bus();
        end else begin
            wait_until(x - SYNC - 1);
            rx_eidle = 1'b0;
            repeat (SYNC + 2) @(negedge clk);
            rx_eidle = 1'b1;
        end
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic g, output int e0);
        sel = 3'b000;
        push_exp(edges + 1, S_IDLE, 0, "R1 flag cleared when disabled");
        push_exp(edges + 1, S_ACT, 0, "R1 act low when disabled");
        repeat (2) @(negedge clk);
        sel = m; gen2 = g;
        e0 = edges + 1;
    endtask

    task automatic mode_run(input logic [2:0] m, input logic g, input int kind,
                            input int w, input string tag);
        int e0;
        int ev;
        set_cfg(m, g, e0);
        push_exp(e0, S_ACT, 1, "R11 act");
        push_exp(e0, S_CRIT, int'(m[1:0]), "R11 crit");
        push_exp(e0 + w - 1, S_IDLE, 0, {tag, " R8 before expiry"});
        push_exp(e0 + w, S_IDLE, 1, {tag, " R8 at expiry"});
        ev = e0 + w + 4;
        push_exp(ev - 1, S_IDLE, 1, "R9 held");
        push_exp(ev, S_IDLE, 0, {tag, " R9 cleared by event"});
        push_exp(ev + w - 1, S_IDLE, 0, {tag, " R8 restarted"});
        fire(kind, ev);
        push_exp(ev + w, S_IDLE, 0, {tag, " R8 event on last edge"});
        push_exp(ev + 2*w - 1, S_IDLE, 0, {tag, " R8 inside"});
        push_exp(ev + 2*w, S_IDLE, 1, {tag, " R8 expiry after late event"});
        fire(kind, ev + w);
        wait_until(ev + 2*w + 1);
    endtask

    initial begin
        int e0;
        int c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset idle", int'(idle), 0);
        check("R1 reset act", int'(act), 0);

        mode_run(3'b100, 1'b0, K_COMMA, W_C1, "R2");
        mode_run(3'b100, 1'b1, K_COMMA, W_C2, "R2");
        mode_run(3'b101, 1'b0, K_TS, W_TS, "R3");
        mode_run(3'b101, 1'b1, K_TS, W_TS, "R3");
        mode_run(3'b110, 1'b0, K_EXIT, W_EX1, "R4/R7");
        mode_run(3'b110, 1'b1, K_EXIT, W_EX2, "R4/R7");
        mode_run(3'b111, 1'b0, K_EXIT, W_C1, "R5/R7");

        // R5: time-based exit check is off at second rate
        set_cfg(3'b111, 1'b1, e0);
        push_exp(e0, S_ACT, 0, "R5 act off at gen2");
        push_exp(e0 + W_C1 + 5, S_IDLE, 0, "R5 no flag at gen2");
        wait_until(e0 + W_C1 + 6);

        // R1: disabled code with other bits set
        set_cfg(3'b011, 1'b0, e0);
        push_exp(e0 + W_C1 + 5, S_IDLE, 0, "R1 disabled code 011");
        push_exp(e0, S_ACT, 0, "R1 act for 011");
        wait_until(e0 + W_C1 + 6);

        // R6: comma while not locked is ignored
        set_cfg(3'b100, 1'b0, e0);
        push_exp(e0 + W_C1 - 1, S_IDLE, 0, "R6 before expiry");
        push_exp(e0 + W_C1, S_IDLE, 1, "R6 invalid comma ignored");
        wait_until(e0 + 29);
        rx_valid = 1'b0; rx_ctl = 4'b0001; rx_data = 32'h0000_00BC;
        @(negedge clk); idle_bus();
        wait_until(e0 + W_C1 + 1);

        // R3: malformed identifier (control flag set) is no event
        set_cfg(3'b101, 1'b0, e0);
        push_exp(e0 + W_TS, S_IDLE, 1, "R3 malformed set ignored");
        wait_until(e0 + 9);
        rx_ctl = 4'b0001; rx_data = 32'h0000_00BC;
        @(negedge clk);
        rx_ctl = 4'b0100; rx_data = 32'h004A_0000;
        @(negedge clk); idle_bus();
        wait_until(e0 + W_TS + 1);

        // R3/R6: invalid word between comma and identifier keeps the pair
        set_cfg(3'b101, 1'b0, e0);
        push_exp(e0 + W_TS, S_IDLE, 0, "R3 gapped set restarts");
        push_exp(e0 + 12 + W_TS - 1, S_IDLE, 0, "R3 gapped before expiry");
        push_exp(e0 + 12 + W_TS, S_IDLE, 1, "R3 gapped expiry");
        wait_until(e0 + 9);
        rx_ctl = 4'b0001; rx_data = 32'h0000_00BC;
        @(negedge clk);
        rx_valid = 1'b0; rx_ctl = 4'b0000; rx_data = '0;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 32'h0045_0000;
        @(negedge clk); idle_bus();
        wait_until(e0 + 12 + W_TS + 1);

        // R10: switching criterion restarts the window
        set_cfg(3'b101, 1'b0, e0);
        wait_until(e0 + 19);
        sel = 3'b110;
        c = e0 + 20;
        push_exp(c, S_CRIT, 2, "R10 crit follows");
        push_exp(e0 + W_TS, S_IDLE, 0, "R10 old window abandoned");
        push_exp(c + W_EX1 - 1, S_IDLE, 0, "R10 new window running");
        push_exp(c + W_EX1, S_IDLE, 1, "R10 new window expiry");
        wait_until(c + W_EX1 + 1);

        // R7: rising edge of electrical idle is no exit event
        rx_eidle = 1'b0;
        set_cfg(3'b110, 1'b0, e0);
        push_exp(e0 + W_EX1, S_IDLE, 1, "R7 rising edge ignored");
        wait_until(e0 + 9);
        rx_eidle = 1'b1;
        wait_until(e0 + W_EX1 + 2);

        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0 hung run", edges);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule